// File: doc/BRIEF.md
# Sound Chip Bus Strobe Sequencer

This block sits between a sound processor's write decoder and three peripheral chips: two programmable sound generators (PSGs) and a speech synthesizer. The processor does not talk to these chips directly. It first writes a byte into one of two holding latches, one for the PSGs and one for speech. It then writes a control byte. A transfer is set off by a bit of the control byte going from 1 to 0, not by the write itself. When the PSG trigger bit falls, two other bits of the same control byte choose which PSG receives the byte and whether the cycle is a register-address write or a data write.

Each transfer becomes a single-clock write strobe. The byte being moved is placed on a registered output bus, and that bus keeps its value until the next transfer. Two more control bits drive the speech chip's reset and test lines as plain registered levels. A combinational status port reports the speech chip's data-request line in a fixed bit position, together with a constant marker bit.

Top module: `snd_bus_sequencer`

## Requirements
- R1: A control write whose bit 2 is 0, when the stored bit 2 from the previous control write was 1, raises exactly one bit of `psg_wr_stb` for exactly one clock, in the cycle after the write.
- R2: In a PSG transfer, control bit 3 = 1 strobes `psg_wr_stb[0]` (first PSG) and bit 3 = 0 strobes `psg_wr_stb[1]` (second PSG).
- R3: In a PSG transfer, `psg_addr_sel` takes control bit 4 (1 = address/register-select cycle, 0 = data cycle) and holds it until the next PSG transfer.
- R4: During a PSG strobe, `psg_bus` carries the PSG latch value as it stood before the clock edge of the control write, and it holds that value until the next PSG transfer. A latch write in the same cycle as the control write only affects later transfers.
- R5: A control write whose bit 6 is 0, when the stored bit 6 was 1, pulses `spk_wr_stb` for one clock in the cycle after the write. `spk_bus` then carries the speech latch value from before that edge and holds it afterwards.
- R6: Each control write copies bit 7 to `spk_reset` and bit 5 to `spk_test`. Both lines appear in the cycle after the write and keep their values between control writes.
- R7: No strobe is produced by a latch write, by a cycle without a control write, or by a control write in which bits 2 and 6 stay high, stay low or rise.
- R8: After reset all outputs except `status_rd` are 0, and the stored bits 2 and 6 are 0, so a first control write with those bits low produces no strobe.
- R9: `status_rd` has bit 7 equal to `spk_drq` and bit 6 equal to 1. Bits 5 to 0 are 0.
- R10: A single control write in which both bit 2 and bit 6 fall produces a PSG strobe and a speech strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write enable |
| ctrl_wdata | input | 8 | Control byte |
| psg_latch_we | input | 1 | PSG holding latch write enable |
| psg_latch_wdata | input | 8 | PSG holding latch data |
| spk_latch_we | input | 1 | Speech holding latch write enable |
| spk_latch_wdata | input | 8 | Speech holding latch data |
| spk_drq | input | 1 | Speech chip data-request line |
| psg_wr_stb | output | 2 | One-clock write strobe per PSG (index 0 = first PSG) |
| psg_addr_sel | output | 1 | 1 = address cycle, 0 = data cycle |
| psg_bus | output | 8 | Byte delivered to the PSGs |
| spk_wr_stb | output | 1 | One-clock speech data strobe |
| spk_bus | output | 8 | Byte delivered to the speech chip |
| spk_reset | output | 1 | Speech chip reset level |
| spk_test | output | 1 | Speech chip direct-data test level |
| status_rd | output | 8 | Status byte |

## Verification
On every cycle the assertions check the following. The PSG strobes are never active on more than one chip at once. Each strobe lasts a single clock, and the output buses stay steady in the cycle after a strobe. A strobe has always been preceded by a control write, and the chip it selects agrees with bit 3 of that write. The reset and test lines follow the previous control write. Other behaviour needs the bench's sequences of writes. That covers whether a transfer takes the old or the new latch value when both are written together, whether a first write after reset stays silent, whether one write can fire both strobes at once, and whether the stored bus contents survive long stretches without a transfer.

// File: rtl/snd_strobe_pkg.sv
package snd_strobe_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_PSG  = 2;
    localparam int PSG_IDX_W = (NUM_PSG > 1) ? $clog2(NUM_PSG) : 1;

    // control byte bit positions (behaviour depends on these)
    localparam int CB_PSG_GO   = 2;
    localparam int CB_PSG_SEL  = 3;
    localparam int CB_PSG_ADDR = 4;
    localparam int CB_SPK_TEST = 5;
    localparam int CB_SPK_GO   = 6;
    localparam int CB_SPK_RST  = 7;

    // status byte bit positions
    localparam int SB_MARKER = 6;
    localparam int SB_DRQ    = 7;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic prev_psg_go;
        logic prev_spk_go;
        logic spk_rst;
        logic spk_tst;
    } ctrl_state_t;

    typedef struct packed {
        byte_t              latch;
        byte_t              bus;
        logic               addr_sel;
        logic [NUM_PSG-1:0] stb;
    } psg_state_t;

    typedef struct packed {
        byte_t latch;
        byte_t bus;
        logic  stb;
    } spk_state_t;

endpackage

// File: rtl/snd_ctrl_edge.sv
module snd_ctrl_edge
    import snd_strobe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_we,
    input  byte_t                ctrl_wdata,
    output logic                 psg_go,
    output logic [PSG_IDX_W-1:0] psg_idx,
    output logic                 psg_addr,
    output logic                 spk_go,
    output logic                 spk_rst,
    output logic                 spk_tst
);

    ctrl_state_t st_d, st_q;

    logic unused_lo;
    assign unused_lo = ^ctrl_wdata[1:0];

    always_comb begin
        st_d     = st_q;
        psg_go   = ctrl_we && st_q.prev_psg_go && !ctrl_wdata[CB_PSG_GO];
        spk_go   = ctrl_we && st_q.prev_spk_go && !ctrl_wdata[CB_SPK_GO];
        psg_idx  = ctrl_wdata[CB_PSG_SEL] ? PSG_IDX_W'(0) : PSG_IDX_W'(1);
        psg_addr = ctrl_wdata[CB_PSG_ADDR];
        if (ctrl_we) begin
            st_d.prev_psg_go = ctrl_wdata[CB_PSG_GO];
            st_d.prev_spk_go = ctrl_wdata[CB_SPK_GO];
            st_d.spk_rst     = ctrl_wdata[CB_SPK_RST];
            st_d.spk_tst     = ctrl_wdata[CB_SPK_TEST];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign spk_rst = st_q.spk_rst;
    assign spk_tst = st_q.spk_tst;

    // R6: lines follow the last control write
    p_lines_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (spk_rst == $past(ctrl_wdata[CB_SPK_RST]))
                 && (spk_tst == $past(ctrl_wdata[CB_SPK_TEST])));

    p_lines_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(spk_rst) && $stable(spk_tst));

endmodule

// File: rtl/snd_psg_port.sv
module snd_psg_port
    import snd_strobe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 latch_we,
    input  byte_t                latch_wdata,
    input  logic                 go,
    input  logic [PSG_IDX_W-1:0] idx,
    input  logic                 addr,
    output logic [NUM_PSG-1:0]   wr_stb,
    output logic                 addr_sel,
    output byte_t                bus
);

    psg_state_t st_d, st_q;
    logic [NUM_PSG-1:0] hit;

    generate
        for (genvar g = 0; g < NUM_PSG; g++) begin : g_chip
            assign hit[g] = go && (idx == PSG_IDX_W'(g));
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.stb = hit;
        if (go) begin
            st_d.bus      = st_q.latch;
            st_d.addr_sel = addr;
        end
        if (latch_we) st_d.latch = latch_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_stb   = st_q.stb;
    assign addr_sel = st_q.addr_sel;
    assign bus      = st_q.bus;

    p_stb_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));

    p_stb_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb) |=> (wr_stb == '0));

    p_bus_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_stb) |=> $stable(bus) && $stable(addr_sel));

endmodule

// File: rtl/snd_spk_port.sv
module snd_spk_port
    import snd_strobe_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  latch_we,
    input  byte_t latch_wdata,
    input  logic  go,
    output logic  wr_stb,
    output byte_t bus
);

    spk_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = go;
        if (go)       st_d.bus   = st_q.latch;
        if (latch_we) st_d.latch = latch_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_stb = st_q.stb;
    assign bus    = st_q.bus;

    p_spk_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    p_spk_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> $stable(bus));

endmodule

// File: rtl/snd_bus_sequencer.sv
module snd_bus_sequencer
    import snd_strobe_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_we,
    input  logic [7:0]   ctrl_wdata,
    input  logic         psg_latch_we,
    input  logic [7:0]   psg_latch_wdata,
    input  logic         spk_latch_we,
    input  logic [7:0]   spk_latch_wdata,
    input  logic         spk_drq,
    output logic [1:0]   psg_wr_stb,
    output logic         psg_addr_sel,
    output logic [7:0]   psg_bus,
    output logic         spk_wr_stb,
    output logic [7:0]   spk_bus,
    output logic         spk_reset,
    output logic         spk_test,
    output logic [7:0]   status_rd
);

    logic                 psg_go, spk_go, psg_addr;
    logic [PSG_IDX_W-1:0] psg_idx;

    snd_ctrl_edge i_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .psg_go     (psg_go),
        .psg_idx    (psg_idx),
        .psg_addr   (psg_addr),
        .spk_go     (spk_go),
        .spk_rst    (spk_reset),
        .spk_tst    (spk_test)
    );

    snd_psg_port i_psg (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch_we    (psg_latch_we),
        .latch_wdata (psg_latch_wdata),
        .go          (psg_go),
        .idx         (psg_idx),
        .addr        (psg_addr),
        .wr_stb      (psg_wr_stb),
        .addr_sel    (psg_addr_sel),
        .bus         (psg_bus)
    );

    snd_spk_port i_spk (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch_we    (spk_latch_we),
        .latch_wdata (spk_latch_wdata),
        .go          (spk_go),
        .wr_stb      (spk_wr_stb),
        .bus         (spk_bus)
    );

    always_comb begin
        status_rd            = '0;
        status_rd[SB_MARKER] = 1'b1;
        status_rd[SB_DRQ]    = spk_drq;
    end

    // R7: a strobe always follows a control write
    p_needs_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|psg_wr_stb) || spk_wr_stb) |-> $past(ctrl_we));

    // R2: selected chip matches bit 3 of that write
    p_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|psg_wr_stb) |-> (psg_wr_stb[0] == $past(ctrl_wdata[CB_PSG_SEL])));

    // R3: cycle type matches bit 4 of that write
    p_cycle_type_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|psg_wr_stb) |-> (psg_addr_sel == $past(ctrl_wdata[CB_PSG_ADDR])));

endmodule

// File: tb/test_snd_bus_sequencer.sv
module test_snd_bus_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic       psg_latch_we = 1'b0;
    logic [7:0] psg_latch_wdata = '0;
    logic       spk_latch_we = 1'b0;
    logic [7:0] spk_latch_wdata = '0;
    logic       spk_drq = 1'b0;
    logic [1:0] psg_wr_stb;
    logic       psg_addr_sel;
    logic [7:0] psg_bus;
    logic       spk_wr_stb;
    logic [7:0] spk_bus;
    logic       spk_reset;
    logic       spk_test;
    logic [7:0] status_rd;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic       m_prev2 = 0, m_prev6 = 0, m_rst = 0, m_tst = 0, m_addr = 0;
    logic [7:0] m_psg_latch = 0, m_spk_latch = 0, m_psg_bus = 0, m_spk_bus = 0;
    logic [1:0] m_psg_stb = 0;
    logic       m_spk_stb = 0;

    always #10 clk = ~clk;

    snd_bus_sequencer i_snd_bus_sequencer (.*);

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [7:0] exp_status(input logic drq);
        return {drq, 1'b1, 6'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, then compare all outputs with the model
    task automatic step(input logic cw, input logic [7:0] cd,
                        input logic pw, input logic [7:0] pd,
                        input logic sw, input logic [7:0] sd,
                        input logic drq);
        @(negedge clk);
        ctrl_we = cw; ctrl_wdata = cd;
        psg_latch_we = pw; psg_latch_wdata = pd;
        spk_latch_we = sw; spk_latch_wdata = sd;
        spk_drq = drq;
        #1;
        chk("R9 status", status_rd, exp_status(drq));
        m_psg_stb = '0;
        m_spk_stb = 1'b0;
        if (cw && m_prev2 && !cd[2]) begin
            m_psg_stb = cd[3] ? 2'b01 : 2'b10;
            m_psg_bus = m_psg_latch;
            m_addr    = cd[4];
        end
        if (cw && m_prev6 && !cd[6]) begin
            m_spk_stb = 1'b1;
            m_spk_bus = m_spk_latch;
        end
        if (cw) begin
            m_prev2 = cd[2]; m_prev6 = cd[6];
            m_rst = cd[7]; m_tst = cd[5];
        end
        if (pw) m_psg_latch = pd;
        if (sw) m_spk_latch = sd;
        @(negedge clk);
        ctrl_we = 0; psg_latch_we = 0; spk_latch_we = 0;
        chk("R1/R2/R7 psg strobe", psg_wr_stb, m_psg_stb);
        chk("R3 addr select", psg_addr_sel, m_addr);
        chk("R4 psg bus", psg_bus, m_psg_bus);
        chk("R5/R7 speech strobe", spk_wr_stb, m_spk_stb);
        chk("R5 speech bus", spk_bus, m_spk_bus);
        chk("R6 reset/test lines", {spk_reset, spk_test}, {m_rst, m_tst});
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 reset strobes", {psg_wr_stb, spk_wr_stb}, 3'b000);
        chk("R8 reset buses", {psg_bus, spk_bus, psg_addr_sel}, 17'h0);
        chk("R8 reset lines", {spk_reset, spk_test}, 2'b00);
        rst_n = 1'b1;
        // R8: first write with bits 2 and 6 low produces nothing
        step(1, 8'h00, 1, 8'hA5, 1, 8'h3C, 0);
        chk("R8 first write silent", {psg_wr_stb, spk_wr_stb}, 3'b000);
        // R1 R2 R3: rise then fall, first PSG, address cycle
        step(1, 8'h1C, 0, 0, 0, 0, 1);
        step(1, 8'h18, 0, 0, 0, 0, 1);
        chk("R2 first PSG", psg_wr_stb, 2'b01);
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R1 one clock only", psg_wr_stb, 2'b00);
        // R2 R3: second PSG, data cycle
        step(1, 8'h04, 1, 8'h5A, 0, 0, 0);
        step(1, 8'h00, 0, 0, 0, 0, 0);
        chk("R2 second PSG", psg_wr_stb, 2'b10);
        chk("R3 data cycle", psg_addr_sel, 1'b0);
        // R4: latch written in same cycle as trigger gives old value
        step(1, 8'h04, 0, 0, 0, 0, 0);
        step(1, 8'h08, 1, 8'hC3, 0, 0, 0);
        chk("R4 old latch", psg_bus, 8'h5A);
        // R7: high to high and low to low give nothing
        step(1, 8'h44, 0, 0, 0, 0, 0);
        step(1, 8'h44, 0, 0, 0, 0, 0);
        chk("R7 no strobe steady high", {psg_wr_stb, spk_wr_stb}, 3'b000);
        // R10: both fall together
        step(1, 8'hA0, 0, 0, 1, 8'h77, 0);
        chk("R10 both strobes", {psg_wr_stb, spk_wr_stb}, 3'b101);
        chk("R5 old speech latch", spk_bus, 8'h3C);
        // randomized traffic
        for (int i = 0; i < 600; i++) begin
            step($urandom_range(0, 1) == 1, 8'($urandom),
                 $urandom_range(0, 3) == 0, 8'($urandom),
                 $urandom_range(0, 3) == 0, 8'($urandom),
                 1'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule